// File: doc/BRIEF.md
# RAM-Backed Fixed Delay Line

This block delays a multi-bit data stream by a fixed number of clock cycles. A cascade of flip-flops would cost one register per stage per bit. Here the samples stay where they are written, in a simple dual-port RAM with one write port and one read port. Only two address counters move. The write counter and the read counter both step by one on every clock. They start one entry apart, so each entry is read back one full lap of the RAM after it was written.

The depth is a power of two chosen by the address-width parameter. The delay from an input sample to the same value on the output is exactly that depth, in clock cycles. A new sample is accepted on every cycle and one is produced on every cycle. The block has no enable, stall or flow control. For the first depth-many cycles after reset the output carries whatever the RAM held before, and a consumer must ignore it.

Top module: `ram_delay_line`

## Requirements
- R1: While `rst_i` is high at a rising edge, `dout_o` is all zeros after that edge.
- R2: On the first clock after reset is released, the read address is entry 0.
- R3: On the first clock after reset is released, the write address is the last entry (all ones).
- R4: Both addresses advance by exactly one on every clock and wrap from the last entry to entry 0.
- R5: The write address and the read address are never equal in the same cycle.
- R6: Counting rising edges from the first edge with `rst_i` low as edge 0, the value on `din_i` at edge k appears on `dout_o` after edge k+DEPTH, where DEPTH = 2**ADDR_W.
- R7: The exact DEPTH-cycle delay holds across many wraps of both addresses and for every bit of the data word.
- R8: Asserting reset in the middle of a stream restarts the addresses, and R6 holds again counting from the new release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on its rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| din_i | input | DATA_W | Sample accepted on every rising edge |
| dout_o | output | DATA_W | Sample taken DEPTH edges earlier |

## Verification
The bench targets the exact delay count first. If the read address started anywhere other than one entry past the write address, or the RAM read were not registered, outputs would appear a cycle early or late. Every random sample would then mismatch. A long random run wraps the addresses dozens of times, so a counter that saturated or skipped at the last entry would corrupt samples right after the wrap. Walking-one and alternating patterns catch a stuck or swapped data bit. A mid-stream reset followed by checks against the new stream catches a design that failed to reload its counters, which would keep the old offset.

// File: rtl/dly_pkg.sv
package dly_pkg;
    // Default geometry of the delay line
    localparam int unsigned DLY_DATA_W_DEF = 16;
    localparam int unsigned DLY_ADDR_W_DEF = 4;
endpackage

// File: rtl/dly_ptr_gen.sv
module dly_ptr_gen #(
    parameter int unsigned ADDR_W = dly_pkg::DLY_ADDR_W_DEF
) (
    input  logic              clk_i,
    input  logic              rst_i,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [ADDR_W-1:0] rd_addr_o
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

    typedef struct packed {
        logic [ADDR_W-1:0] wr;
        logic [ADDR_W-1:0] rd;
    } ptr_t;

    ptr_t ptr_d, ptr_q;

    always_comb begin
        ptr_d.wr = ptr_q.wr + STEP;
        ptr_d.rd = ptr_q.rd + STEP;
        if (rst_i) begin
            ptr_d.wr = '1;
            ptr_d.rd = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        ptr_q <= ptr_d;
    end

    assign wr_addr_o = ptr_q.wr;
    assign rd_addr_o = ptr_q.rd;

    // R2
    rd_start_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> ptr_q.rd == '0);

    // R3
    wr_start_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> ptr_q.wr == '1);

    // R4
    rd_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(rst_i) |-> ptr_q.rd == $past(ptr_q.rd) + STEP);

    // R4
    wr_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(rst_i) |-> ptr_q.wr == $past(ptr_q.wr) + STEP);
endmodule

// File: rtl/dly_dpram.sv
module dly_dpram #(
    parameter int unsigned DATA_W = dly_pkg::DLY_DATA_W_DEF,
    parameter int unsigned ADDR_W = dly_pkg::DLY_ADDR_W_DEF
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam int unsigned ENTRIES = 1 << ADDR_W;

    logic [DATA_W-1:0] store_q [ENTRIES];
    logic [DATA_W-1:0] rd_data_q;

    // One write and one registered read on every edge
    always_ff @(posedge clk_i) begin
        store_q[wr_addr_i] <= wr_data_i;
        rd_data_q          <= store_q[rd_addr_i];
    end

    assign rd_data_o = rd_data_q;

    // R5
    port_clash_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_addr_i != rd_addr_i);
endmodule

// File: rtl/ram_delay_line.sv
module ram_delay_line #(
    parameter int unsigned DATA_W = dly_pkg::DLY_DATA_W_DEF,
    parameter int unsigned ADDR_W = dly_pkg::DLY_ADDR_W_DEF
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [DATA_W-1:0] din_i,
    output logic [DATA_W-1:0] dout_o
);
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] ram_rd_data;
    logic [DATA_W-1:0] dout_d, dout_q;

    dly_ptr_gen #(.ADDR_W(ADDR_W)) u_ptr (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .wr_addr_o (wr_addr),
        .rd_addr_o (rd_addr)
    );

    dly_dpram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .wr_addr_i (wr_addr),
        .wr_data_i (din_i),
        .rd_addr_i (rd_addr),
        .rd_data_o (ram_rd_data)
    );

    // Output stage: the last of the DEPTH cycles of latency
    always_comb begin
        dout_d = ram_rd_data;
        if (rst_i) dout_d = '0;
    end

    always_ff @(posedge clk_i) begin
        dout_q <= dout_d;
    end

    assign dout_o = dout_q;

    // R1
    out_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> dout_o == '0);

    // R5
    addr_gap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_addr + ADDR_W'(1) == rd_addr);
endmodule

// File: tb/ram_delay_line_bench.sv
`timescale 1ns/1ps
module ram_delay_line_bench;
    localparam int unsigned DATA_W = 16;
    localparam int unsigned ADDR_W = 4;
    localparam int unsigned DEPTH  = 1 << ADDR_W;
    localparam int unsigned HIST   = 2048;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [DATA_W-1:0] din = '0;
    logic [DATA_W-1:0] dout;

    int unsigned checks = 0;
    int unsigned fails  = 0;
    int unsigned n      = 0;
    bit          done   = 1'b0;
    logic [DATA_W-1:0] hist [HIST];

    always #2 clk = ~clk;

    ram_delay_line #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram_delay_line (
        .clk_i  (clk),
        .rst_i  (rst),
        .din_i  (din),
        .dout_o (dout)
    );

    function automatic logic [DATA_W-1:0] walk_one(input int unsigned i);
        return DATA_W'(1) << (i % DATA_W);
    endfunction

    function automatic logic [DATA_W-1:0] expected_at(input int unsigned edges);
        return hist[(edges - 1 - DEPTH) % HIST];
    endfunction

    task automatic check(input string req, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: dout=%h expected=%h (edge %0d)", req, act, exp, n);
        end
    endtask

    // Drive one sample, clock it in, and compare once the line has filled
    task automatic cycle(input logic [DATA_W-1:0] v, input string req);
        din = v;
        hist[n % HIST] = v;
        @(posedge clk);
        @(negedge clk);
        n++;
        if (n > DEPTH) check(req, dout, expected_at(n));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        for (int i = 0; i < 3; i++) begin
            din = DATA_W'($urandom);
            @(posedge clk);
            @(negedge clk);
            check("R1", dout, '0);
        end
        rst = 1'b0;
        n = 0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();
        // R2 R3 R4 R5 R6: random stream, exact delay from the first sample
        for (int i = 0; i < 100; i++) cycle(DATA_W'($urandom), "R6 (R2 R3 R4 R5)");
        // R7: long run across many wraps
        for (int i = 0; i < 600; i++) cycle(DATA_W'($urandom), "R7");
        // R7: every bit, walking one and alternating words
        for (int i = 0; i < 48; i++) cycle(walk_one(i), "R7 walk");
        for (int i = 0; i < 40; i++) cycle((i % 2 == 0) ? '1 : '0, "R7 alt");
        for (int i = 0; i < 20; i++) cycle(DATA_W'(16'hA5C3), "R7 const");
        // R8: reset in mid-stream, then the delay restarts
        do_reset();
        for (int i = 0; i < 300; i++) cycle(DATA_W'($urandom), "R8");
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule